// File: doc/BRIEF.md
# Four-Bank Pin Controller with Masked Output Writes

This block is a memory-mapped general purpose pin controller. It serves four banks of pins, 32, 22, 32 and 32 wide, over a plain 32-bit register bus with separate read and write strobes. For each bank, software can set which pins are outputs, which outputs may drive their pads, and the value each output carries. It can also read back the levels seen on the pads after a two-flop synchronizer.

Output values can be changed in two ways. The first is a full 32-bit data word. The second is a pair of half-word registers in which the upper 16 bits act as an active-low write mask over the lower 16 data bits. With the half-word registers, software can set or clear any subset of pins in one write, with no read-modify-write. The address range kept for interrupt control reads as zero and ignores writes. Pads are given as flat 128-bit vectors with 32 slots per bank. The ten slots that bank 1 does not implement are inert.

Top module: `gpio_mb_top`

## Requirements
- R1: After reset, every direction, output-enable and output data bit is 0, `pad_oe` and `pad_out` are all zero, and `bus_rdata` is zero.
- R2: Bank 1 implements only pins 0..21. Its bits 22..31 read as 0 in every register, ignore writes, and keep `pad_oe` and `pad_out` at 0. The other banks implement all 32 pins.
- R3: The full output word of bank N is at byte offset 0x040 + 4*N. A write replaces all 32 output bits, and a read returns the current output values.
- R4: The masked register at 0x000 + 8*N controls pins 0..15 of bank N. Pin k takes write data bit k only when mask bit 16+k is 0. A mask bit of 1 leaves pin k unchanged, and pins 16..31 are never touched.
- R5: The masked register at 0x004 + 8*N controls pins 16..31 of bank N. Data bit k goes to pin 16+k when mask bit 16+k is 0. Pins 0..15 are never touched.
- R6: Both masked registers are write-only and read as 0.
- R7: The direction register of bank N is at 0x204 + 0x40*N and can be read and written. A 1 makes the pin an output.
- R8: The output-enable register of bank N is at 0x208 + 0x40*N. The pad enable for a pin is 1 only when both its direction bit and its enable bit are 1. `pad_out` always carries the output data value.
- R9: The read-only register at 0x060 + 4*N returns the pad levels of bank N through a two-flop synchronizer. A read strobed on the first or second clock edge after a pad change returns the old level, and one strobed on the third edge returns the new level.
- R10: Offsets 0x20C through 0x224 + 0x40*N (the reserved interrupt range), and every other unmapped or unaligned offset, read as 0. Writes to them change no register and no pad output.
- R11: Read data is registered. It appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`, and it is 0 in any cycle that follows an edge without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 128 | Pad levels, bank N at bits 32*N+31..32*N |
| pad_out | output | 128 | Output value per pin |
| pad_oe | output | 128 | Pad drive enable per pin |

## Verification
The embedded properties watch the masked-write rules on every cycle: masked pins keep their value, the other half-word is untouched, bits only change when a write is strobed, and unimplemented bits stay zero. They also check that the synchronized value trails the pads by two cycles and that write-only, reserved and idle reads return zero. Only the bench scenarios can show the address map itself: which offset reaches which bank, the combined pad-enable rule at the pins, the exact edge on which a pad change becomes readable, and that writes to reserved offsets leave every real register and pad intact.

// File: rtl/gpio_mb_pkg.sv
// Package: shared sizes, address map constants and the per-bank write strobe
// type for the four-bank pin controller.
// Assumes byte addressing with word-aligned register offsets.
package gpio_mb_pkg;

    localparam int NUM_BANKS   = 4;
    localparam int DATA_W      = 32;
    localparam int HALF_W      = DATA_W / 2;
    localparam int ADDR_W      = 12;
    localparam int SYNC_STAGES = 2;

    // Address map (byte offsets)
    localparam int MASK_BASE   = 'h000;
    localparam int MASK_STRIDE = 8;
    localparam int HI_OFFSET   = 4;
    localparam int FULL_BASE   = 'h040;
    localparam int PINS_BASE   = 'h060;
    localparam int WORD_STRIDE = 4;
    localparam int DIR_BASE    = 'h204;
    localparam int OEN_BASE    = 'h208;
    localparam int CFG_STRIDE  = 'h040;

    // Number of implemented pins in a bank
    function automatic int bank_pins(input int b);
        case (b)
            1:       return 22;
            default: return 32;
        endcase
    endfunction

    // Per-bank write strobes decoded from the bus
    typedef struct packed {
        logic lo_masked;
        logic hi_masked;
        logic full;
        logic dir;
        logic oen;
    } bank_wr_t;

endpackage

// File: rtl/gpio_mb_sync.sv
// Module: multi-stage synchronizer for pad levels.
// Assumes pad inputs are asynchronous to clk; output trails input by STAGES clocks.
module gpio_mb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift pad levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    // Cycles since reset, saturating, to gate the latency check
    logic [1:0] warm_q;

    // Count up to two cycles after reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R9: synchronized value equals the input two clocks earlier
    generate
        if (STAGES == 2) begin : g_lat_chk
            a_r9_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (dout == $past(din, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_mb_bank.sv
// Module: register set of one bank (direction, output enable, output data)
// with full-word and masked half-word update paths.
// Assumes at most one write strobe per cycle; bits at or above PINS are unimplemented.
module gpio_mb_bank
    import gpio_mb_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dir,
    output logic [DATA_W-1:0] oen,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe
);

    localparam logic [DATA_W-1:0] IMPL =
        (PINS >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << PINS) - DATA_W'(1));

    logic [DATA_W-1:0] dout_next;

    // Compute the next output word from full or masked writes
    always_comb begin
        dout_next = dout;
        if (wr.full) begin
            dout_next = wdata;
        end
        if (wr.lo_masked) begin
            for (int k = 0; k < HALF_W; k++) begin
                if (!wdata[HALF_W + k]) dout_next[k] = wdata[k];
            end
        end
        if (wr.hi_masked) begin
            for (int k = 0; k < HALF_W; k++) begin
                if (!wdata[HALF_W + k]) dout_next[HALF_W + k] = wdata[k];
            end
        end
    end

    // Hold output data, limited to implemented pins
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= dout_next & IMPL;
    end

    // Hold direction bits
    always_ff @(posedge clk) begin
        if (!rst_n)      dir <= '0;
        else if (wr.dir) dir <= wdata & IMPL;
    end

    // Hold output-enable bits
    always_ff @(posedge clk) begin
        if (!rst_n)      oen <= '0;
        else if (wr.oen) oen <= wdata & IMPL;
    end

    assign pad_out = dout;
    assign pad_oe  = dir & oen;

    // R4: masked low write keeps masked pins of the low half
    a_r4_lo_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.lo_masked && !wr.full) |=>
            ((dout[HALF_W-1:0] & $past(wdata[DATA_W-1:HALF_W])) ==
             ($past(dout[HALF_W-1:0]) & $past(wdata[DATA_W-1:HALF_W]))));

    // R4: masked low write never touches the high half
    a_r4_lo_spares_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.lo_masked && !wr.full && !wr.hi_masked) |=>
            (dout[DATA_W-1:HALF_W] == $past(dout[DATA_W-1:HALF_W])));

    // R5: masked high write never touches the low half
    a_r5_hi_spares_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.hi_masked && !wr.full && !wr.lo_masked) |=>
            (dout[HALF_W-1:0] == $past(dout[HALF_W-1:0])));

    // R3: output data only changes on a data write
    a_r3_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.full || wr.lo_masked || wr.hi_masked) |=> $stable(dout));

    // R2: unimplemented bits stay zero in every register
    a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout | dir | oen) & ~IMPL) == '0);

endmodule

// File: rtl/gpio_mb_regif.sv
// Module: bus decoder and registered read multiplexer for the four banks.
// Assumes single-cycle strobes; unmapped and unaligned offsets decode to nothing.
module gpio_mb_regif
    import gpio_mb_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic [ADDR_W-1:0]                   bus_addr,
    output logic [DATA_W-1:0]                   bus_rdata,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_dout,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_dir,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_oen,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_pins,
    output bank_wr_t [NUM_BANKS-1:0]            bank_wr
);

    logic [DATA_W-1:0] rd_mux;

    // Decode write strobes per bank
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
            localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(MASK_BASE + MASK_STRIDE * b);
            localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(MASK_BASE + MASK_STRIDE * b + HI_OFFSET);
            localparam logic [ADDR_W-1:0] A_FULL = ADDR_W'(FULL_BASE + WORD_STRIDE * b);
            localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_BASE + CFG_STRIDE * b);
            localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(OEN_BASE + CFG_STRIDE * b);
            assign bank_wr[b].lo_masked = bus_wr && (bus_addr == A_LO);
            assign bank_wr[b].hi_masked = bus_wr && (bus_addr == A_HI);
            assign bank_wr[b].full      = bus_wr && (bus_addr == A_FULL);
            assign bank_wr[b].dir       = bus_wr && (bus_addr == A_DIR);
            assign bank_wr[b].oen       = bus_wr && (bus_addr == A_OEN);
        end
    endgenerate

    // Select the readable register addressed by the bus
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(FULL_BASE + WORD_STRIDE * b)) rd_mux = bank_dout[b];
            if (bus_addr == ADDR_W'(PINS_BASE + WORD_STRIDE * b)) rd_mux = bank_pins[b];
            if (bus_addr == ADDR_W'(DIR_BASE + CFG_STRIDE * b))   rd_mux = bank_dir[b];
            if (bus_addr == ADDR_W'(OEN_BASE + CFG_STRIDE * b))   rd_mux = bank_oen[b];
        end
    end

    // Register read data; zero when no read is strobed
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    // R11: idle cycles return zero
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R6: masked registers read as zero
    a_r6_masked_wo: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr < ADDR_W'(MASK_BASE + MASK_STRIDE * NUM_BANKS)) |=> (bus_rdata == '0));

    // R10: reserved interrupt range of bank 0 reads as zero
    a_r10_irq_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= ADDR_W'('h20C) && bus_addr <= ADDR_W'('h227)) |=> (bus_rdata == '0));

endmodule

// File: rtl/gpio_mb_top.sv
// Module: four-bank pin controller top; instantiates per-bank registers and
// synchronizers and the shared bus interface.
// Assumes pad vectors use 32 slots per bank; unimplemented slots are ignored.
module gpio_mb_top
    import gpio_mb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_BANKS*DATA_W-1:0]   pad_in,
    output logic [NUM_BANKS*DATA_W-1:0]   pad_out,
    output logic [NUM_BANKS*DATA_W-1:0]   pad_oe
);

    logic [NUM_BANKS-1:0][DATA_W-1:0] dout_a;
    logic [NUM_BANKS-1:0][DATA_W-1:0] dir_a;
    logic [NUM_BANKS-1:0][DATA_W-1:0] oen_a;
    logic [NUM_BANKS-1:0][DATA_W-1:0] pins_a;
    bank_wr_t [NUM_BANKS-1:0]         wr_a;

    gpio_mb_regif i_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata),
        .bank_dout (dout_a),
        .bank_dir  (dir_a),
        .bank_oen  (oen_a),
        .bank_pins (pins_a),
        .bank_wr   (wr_a)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int PINS = bank_pins(b);
            localparam logic [DATA_W-1:0] IMPL =
                (PINS >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << PINS) - DATA_W'(1));

            logic [DATA_W-1:0] pad_slice;
            logic [DATA_W-1:0] out_slice;
            logic [DATA_W-1:0] oe_slice;
            logic [DATA_W-1:0] dout_b;
            logic [DATA_W-1:0] dir_b;
            logic [DATA_W-1:0] oen_b;
            logic [DATA_W-1:0] pins_b;

            assign pad_slice = pad_in[b*DATA_W +: DATA_W] & IMPL;

            gpio_mb_sync #(
                .WIDTH  (DATA_W),
                .STAGES (SYNC_STAGES)
            ) i_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (pad_slice),
                .dout  (pins_b)
            );

            gpio_mb_bank #(
                .PINS (PINS)
            ) i_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr      (wr_a[b]),
                .wdata   (bus_wdata),
                .dout    (dout_b),
                .dir     (dir_b),
                .oen     (oen_b),
                .pad_out (out_slice),
                .pad_oe  (oe_slice)
            );

            assign dout_a[b] = dout_b;
            assign dir_a[b]  = dir_b;
            assign oen_a[b]  = oen_b;
            assign pins_a[b] = pins_b;
            assign pad_out[b*DATA_W +: DATA_W] = out_slice;
            assign pad_oe[b*DATA_W +: DATA_W]  = oe_slice;
        end
    endgenerate

    // R8: a pad is never enabled unless it is configured as an output
    a_r8_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[DATA_W-1:0] & ~dir_a[0]) == '0);

endmodule

// File: tb/test_gpio_mb_top.sv
// Bench for the four-bank pin controller: vector table, then directed tests.
module test_gpio_mb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_wr;
    logic         bus_rd;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [127:0] pad_in;
    logic [127:0] pad_out;
    logic [127:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_mb_top i_gpio_mb_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Vector: {read, req, addr, wdata, expected}
    localparam int NV = 22;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 4'd3,  12'h044, 32'hFFFF_FFFF, 32'h0},           // R3 bank1 full write
        {1'b1, 4'd2,  12'h044, 32'h0,         32'h003F_FFFF},   // R2 bank1 width
        {1'b0, 4'd3,  12'h040, 32'h1234_5678, 32'h0},           // R3
        {1'b1, 4'd3,  12'h040, 32'h0,         32'h1234_5678},   // R3 readback
        {1'b0, 4'd4,  12'h000, 32'hFF00_00AB, 32'h0},           // R4 pins 0..7
        {1'b1, 4'd4,  12'h040, 32'h0,         32'h1234_56AB},   // R4
        {1'b0, 4'd5,  12'h004, 32'h0000_BEEF, 32'h0},           // R5 all high pins
        {1'b1, 4'd5,  12'h040, 32'h0,         32'hBEEF_56AB},   // R5
        {1'b0, 4'd5,  12'h004, 32'hFFFE_0000, 32'h0},           // R5 clear pin 16
        {1'b1, 4'd5,  12'h040, 32'h0,         32'hBEEE_56AB},   // R5
        {1'b1, 4'd6,  12'h000, 32'h0,         32'h0},           // R6
        {1'b1, 4'd6,  12'h004, 32'h0,         32'h0},           // R6
        {1'b0, 4'd5,  12'h00C, 32'h0000_0000, 32'h0},           // R5 bank1 high
        {1'b1, 4'd5,  12'h044, 32'h0,         32'h0000_FFFF},   // R5
        {1'b0, 4'd7,  12'h244, 32'hFFFF_FFFF, 32'h0},           // R7 bank1 dir
        {1'b1, 4'd2,  12'h244, 32'h0,         32'h003F_FFFF},   // R2 dir width
        {1'b0, 4'd7,  12'h2C4, 32'hA5A5_0F0F, 32'h0},           // R7 bank3 dir
        {1'b1, 4'd7,  12'h2C4, 32'h0,         32'hA5A5_0F0F},   // R7
        {1'b0, 4'd4,  12'h008, 32'h0000_1234, 32'h0},           // R4 bank1 low
        {1'b1, 4'd4,  12'h044, 32'h0,         32'h0000_1234},   // R4
        {1'b0, 4'd5,  12'h01C, 32'h00FF_1200, 32'h0},           // R5 bank3 partial
        {1'b1, 4'd5,  12'h04C, 32'h0,         32'h1200_0000}    // R5
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 rdata", {96'b0, bus_rdata}, '0);
        bus_read(12'h040, rd); check("R1 data", {96'b0, rd}, '0);
        bus_read(12'h204, rd); check("R1 dir", {96'b0, rd}, '0);
        bus_read(12'h2C8, rd); check("R1 oen", {96'b0, rd}, '0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][80]) begin
                bus_read(VEC[i][75:64], rd);
                check($sformatf("R%0d vec%0d", VEC[i][79:76], i), {96'b0, rd}, {96'b0, VEC[i][31:0]});
            end else begin
                bus_write(VEC[i][75:64], VEC[i][63:32]);
            end
        end

        // R8: pad enable needs both direction and enable
        bus_write(12'h204, 32'h0000_00F0);
        bus_write(12'h208, 32'h0000_003C);
        check("R8 bank0 oe", {96'b0, pad_oe[31:0]}, {96'b0, 32'h0000_0030});
        check("R8 bank0 out", {96'b0, pad_out[31:0]}, {96'b0, 32'hBEEE_56AB});
        check("R8 bank3 oe off", {96'b0, pad_oe[127:96]}, '0);
        bus_write(12'h2C8, 32'hFFFF_FFFF);
        check("R8 bank3 oe", {96'b0, pad_oe[127:96]}, {96'b0, 32'hA5A5_0F0F});
        check("R8 bank3 out", {96'b0, pad_out[127:96]}, {96'b0, 32'h1200_0000});
        bus_write(12'h248, 32'hFFFF_FFFF);
        check("R2 bank1 oe", {96'b0, pad_oe[63:32]}, {96'b0, 32'h003F_FFFF});

        // R2: bank1 pin value ignores unimplemented pads
        pad_in[63:32] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        bus_read(12'h064, rd); check("R2 bank1 pins", {96'b0, rd}, {96'b0, 32'h003F_FFFF});

        // R9: two-flop latency on bank2
        pad_in[95:64] = 32'hCAFE_0001;
        bus_read(12'h068, rd); check("R9 edge1 old", {96'b0, rd}, '0);
        bus_read(12'h068, rd); check("R9 edge2 old", {96'b0, rd}, '0);
        bus_read(12'h068, rd); check("R9 edge3 new", {96'b0, rd}, {96'b0, 32'hCAFE_0001});

        // R10: reserved interrupt range and unmapped offsets
        for (int a = 'h20C; a <= 'h224; a += 4) begin
            bus_write(12'(a), 32'hFFFF_FFFF);
            bus_read(12'(a), rd);
            check($sformatf("R10 irq %h", a), {96'b0, rd}, '0);
        end
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_write(12'h070, 32'hFFFF_FFFF);
        bus_write(12'h041, 32'hFFFF_FFFF);
        bus_read(12'h100, rd); check("R10 unmapped 100", {96'b0, rd}, '0);
        bus_read(12'h070, rd); check("R10 unmapped 070", {96'b0, rd}, '0);
        bus_read(12'h204, rd); check("R10 dir kept", {96'b0, rd}, {96'b0, 32'h0000_00F0});
        bus_read(12'h208, rd); check("R10 oen kept", {96'b0, rd}, {96'b0, 32'h0000_003C});
        bus_read(12'h040, rd); check("R10 data kept", {96'b0, rd}, {96'b0, 32'hBEEE_56AB});
        check("R10 pads kept", {96'b0, pad_oe[31:0]}, {96'b0, 32'h0000_0030});

        // R11: registered read, zero when idle
        bus_read(12'h204, rd); check("R11 read", {96'b0, rd}, {96'b0, 32'h0000_00F0});
        @(negedge clk);
        check("R11 idle zero", {96'b0, bus_rdata}, '0);

        finish_run();
    end

endmodule